// File: doc/BRIEF.md
# LPI Highest-Priority Pending Selector

This block walks the implemented range of locally delivered message interrupts, one ID per clock. For each ID it finds out whether the interrupt is pending and enabled, and whether it beats the best interrupt already chosen from the other interrupt classes. The caller gives the incoming best candidate (ID, priority, group) and pulses an update request. The block then sweeps the range, merges every qualifying LPI into that candidate, and pulses `done` with the final winner. A `newWinner` flag marks a result where some LPI displaced the incoming candidate.

The pending state comes from a byte-wide bitmap port: the block drives a byte address and reads one byte back in the same cycle. Priority and enable come from a configuration port that is indexed by the offset of the ID from the start of the LPI range. The range is set by a width code `idBits` and clamped to a build-time maximum. The selector never touches table memory itself. The surrounding logic answers the two read ports combinationally.

Top module: `lpi_hppi_sel`

## Requirements
- R1: After reset, `busy`, `done` and `newWinner` are low.
- R2: A request sampled on a clock edge starts a sweep in which one ID is examined per clock. When the range holds N IDs (N ≥ 1), `done` is high for exactly one cycle, following the Nth rising edge after the edge that sampled the request. `busy` is high from the sampling edge until that point and is never high together with `done`.
- R3: The examined IDs run upward from 8192 to 2^(k+1)−1, where k is `idBits` clamped to `MAX_ID_BITS`. If that upper bound is below 8192, the range is empty: `done` rises on the sampling edge itself and the outputs equal the incoming candidate.
- R4: An LPI qualifies only when its pending bit is 1, its enable bit is 1 and `g1nsEn` is 1. When any of the three is 0, the LPI has no effect on the result.
- R5: The configuration byte carries the priority in bits 7:2 and the enable in bit 0. The effective priority is bits 7:2 with two zero bits appended; bit 1 is ignored. A numerically lower priority wins.
- R6: On equal priority, the lower ID wins. An incoming candidate with a lower ID is kept against an LPI of the same priority, and among LPIs the lowest ID is kept.
- R7: A winning LPI is reported with group code 2 (non-secure Group 1). If no LPI wins, the incoming group code passes through unchanged.
- R8: While ID i is examined, `pendAddr` is i>>3, the pending bit is bit i[2:0] of `pendByte`, and `cfgIdx` is i−8192.
- R9: `newWinner` is high only while `done` is high, and only when at least one LPI replaced the incoming candidate.
- R10: A request during a sweep discards the partial result. It reloads the incoming candidate and restarts from ID 8192, with R2 timing counted from the new request.
- R11: An incoming priority of 0xFF means nothing is pending, so any qualifying LPI replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| updateReq | input | 1 | Start or restart a sweep |
| idBits | input | 5 | ID width code that sets the upper end of the range |
| g1nsEn | input | 1 | Non-secure Group 1 enable |
| bestIdIn | input | MAX_ID_BITS+1 | ID of the incoming best candidate |
| bestPrioIn | input | 8 | Priority of the incoming best candidate (0xFF = none) |
| bestGrpIn | input | 2 | Group code of the incoming best candidate |
| pendAddr | output | MAX_ID_BITS-2 | Byte address into the pending bitmap |
| pendByte | input | 8 | Pending bitmap byte at `pendAddr` |
| cfgIdx | output | MAX_ID_BITS+1 | Configuration entry index |
| cfgByte | input | 8 | Configuration byte at `cfgIdx` |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle completion pulse |
| winId | output | MAX_ID_BITS+1 | Winning ID |
| winPrio | output | 8 | Winning priority |
| winGrp | output | 2 | Winning group code |
| newWinner | output | 1 | An LPI displaced the incoming candidate |

## Verification
The full 8192-ID range is swept under several patterns:
- An empty bitmap, and a range code that leaves no IDs. These separate a pass-through result from a replaced one.
- A single pending LPI whose configuration byte has bit 1 set. This shows the address split, the priority masking and the group code.
- The same LPI with its enable cleared, and again with the group enable cleared. This tells the three qualification gates apart.
- A dense arithmetic pattern of pending bits, enables and priorities. The bench computes the winner from the rules alone, so the tie-break among many equal priorities is exercised.
- A restart in the middle of a sweep, and an oversized range code that must clamp. These show that the partial result is dropped and that the sweep length follows the clamped range.

// File: rtl/lpi_sel_pkg.sv
package lpi_sel_pkg;
  localparam int LPI_BASE = 8192;

  typedef enum logic [1:0] {
    GRP_G0   = 2'd0,
    GRP_G1S  = 2'd1,
    GRP_G1NS = 2'd2
  } grp_e;

  typedef struct packed {
    logic load;   // capture incoming candidate, clear replaced flag
    logic step;   // evaluate the current ID
  } scan_strobe_t;
endpackage

// File: rtl/lpi_scan_ctrl.sv
module lpi_scan_ctrl
  import lpi_sel_pkg::*;
#(
  parameter int MAX_ID_BITS = 15,
  localparam int ID_W = MAX_ID_BITS + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            updateReq,
  input  logic [4:0]      idBits,
  output scan_strobe_t    strobe,
  output logic [ID_W-1:0] curId,
  output logic            busy,
  output logic            done
);
  localparam logic [4:0] MAX_BITS_C = 5'(MAX_ID_BITS);
  localparam logic [ID_W-1:0] BASE_ID = ID_W'(LPI_BASE);

  logic [4:0]      bitsClamped;
  logic [31:0]     lastWide;
  logic            rangeEmpty;
  logic [ID_W-1:0] curQ;
  logic [ID_W-1:0] lastQ;
  logic            busyQ;
  logic            doneQ;

  // Upper end of the range from the clamped width code
  always_comb begin
    bitsClamped = (idBits > MAX_BITS_C) ? MAX_BITS_C : idBits;
    lastWide    = (32'd1 << (bitsClamped + 5'd1)) - 32'd1;
    rangeEmpty  = (lastWide < 32'(LPI_BASE));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curQ  <= BASE_ID;
      lastQ <= BASE_ID;
      busyQ <= 1'b0;
      doneQ <= 1'b0;
    end else if (updateReq) begin
      curQ  <= BASE_ID;
      lastQ <= lastWide[ID_W-1:0];
      busyQ <= !rangeEmpty;
      doneQ <= rangeEmpty;
    end else if (busyQ) begin
      if (curQ == lastQ) begin
        busyQ <= 1'b0;
        doneQ <= 1'b1;
      end else begin
        curQ  <= curQ + 1'b1;
        doneQ <= 1'b0;
      end
    end else begin
      doneQ <= 1'b0;
    end
  end

  always_comb begin
    strobe.load = updateReq;
    strobe.step = busyQ && !updateReq;
  end

  assign curId = curQ;
  assign busy  = busyQ;
  assign done  = doneQ;
endmodule

// File: rtl/lpi_best_dp.sv
module lpi_best_dp
  import lpi_sel_pkg::*;
#(
  parameter int MAX_ID_BITS = 15,
  localparam int ID_W = MAX_ID_BITS + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  scan_strobe_t    strobe,
  input  logic [ID_W-1:0] curId,
  input  logic            g1nsEn,
  input  logic [ID_W-1:0] bestIdIn,
  input  logic [7:0]      bestPrioIn,
  input  logic [1:0]      bestGrpIn,
  input  logic [7:0]      pendByte,
  input  logic [7:0]      cfgByte,
  input  logic            done,
  output logic [ID_W-1:0] winId,
  output logic [7:0]      winPrio,
  output logic [1:0]      winGrp,
  output logic            newWinner
);
  logic [ID_W-1:0] bestIdQ;
  logic [7:0]      bestPrioQ;
  logic [1:0]      bestGrpQ;
  logic            replacedQ;
  logic            pendBit;
  logic [7:0]      lpiPrio;
  logic            qualifies;
  logic            beats;

  always_comb begin
    pendBit   = pendByte[curId[2:0]];
    lpiPrio   = {cfgByte[7:2], 2'b00};
    qualifies = strobe.step && pendBit && cfgByte[0] && g1nsEn;
    beats     = (lpiPrio < bestPrioQ) ||
                ((lpiPrio == bestPrioQ) && (curId < bestIdQ));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bestIdQ   <= '0;
      bestPrioQ <= 8'hFF;
      bestGrpQ  <= GRP_G0;
      replacedQ <= 1'b0;
    end else if (strobe.load) begin
      bestIdQ   <= bestIdIn;
      bestPrioQ <= bestPrioIn;
      bestGrpQ  <= bestGrpIn;
      replacedQ <= 1'b0;
    end else if (qualifies && beats) begin
      bestIdQ   <= curId;
      bestPrioQ <= lpiPrio;
      bestGrpQ  <= GRP_G1NS;
      replacedQ <= 1'b1;
    end
  end

  assign winId     = bestIdQ;
  assign winPrio   = bestPrioQ;
  assign winGrp    = bestGrpQ;
  assign newWinner = done && replacedQ;
endmodule

// File: rtl/lpi_hppi_sel.sv
module lpi_hppi_sel
  import lpi_sel_pkg::*;
#(
  parameter int MAX_ID_BITS = 15,
  localparam int ID_W = MAX_ID_BITS + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            updateReq,
  input  logic [4:0]      idBits,
  input  logic            g1nsEn,
  input  logic [ID_W-1:0] bestIdIn,
  input  logic [7:0]      bestPrioIn,
  input  logic [1:0]      bestGrpIn,
  output logic [ID_W-4:0] pendAddr,
  input  logic [7:0]      pendByte,
  output logic [ID_W-1:0] cfgIdx,
  input  logic [7:0]      cfgByte,
  output logic            busy,
  output logic            done,
  output logic [ID_W-1:0] winId,
  output logic [7:0]      winPrio,
  output logic [1:0]      winGrp,
  output logic            newWinner
);
  scan_strobe_t    strobe;
  logic [ID_W-1:0] curId;

  lpi_scan_ctrl #(.MAX_ID_BITS(MAX_ID_BITS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .updateReq (updateReq),
    .idBits    (idBits),
    .strobe    (strobe),
    .curId     (curId),
    .busy      (busy),
    .done      (done)
  );

  lpi_best_dp #(.MAX_ID_BITS(MAX_ID_BITS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .curId      (curId),
    .g1nsEn     (g1nsEn),
    .bestIdIn   (bestIdIn),
    .bestPrioIn (bestPrioIn),
    .bestGrpIn  (bestGrpIn),
    .pendByte   (pendByte),
    .cfgByte    (cfgByte),
    .done       (done),
    .winId      (winId),
    .winPrio    (winPrio),
    .winGrp     (winGrp),
    .newWinner  (newWinner)
  );

  assign pendAddr = curId[ID_W-1:3];
  assign cfgIdx   = curId - ID_W'(LPI_BASE);
endmodule

// File: rtl/lpi_hppi_sel_chk.sv
module lpi_hppi_sel_chk #(
  parameter int MAX_ID_BITS = 15,
  localparam int ID_W = MAX_ID_BITS + 1
) (
  input logic            clk,
  input logic            rstN,
  input logic            updateReq,
  input logic            g1nsEn,
  input logic [7:0]      bestPrioIn,
  input logic [ID_W-4:0] pendAddr,
  input logic            busy,
  input logic            done,
  input logic [ID_W-1:0] winId,
  input logic [7:0]      winPrio,
  input logic [1:0]      winGrp,
  input logic            newWinner
);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    (done && !updateReq) |=> !done);

  assert_busy_done_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  assert_new_only_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    newWinner |-> done);

  assert_prio_nonincr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !updateReq) |=> (winPrio <= $past(winPrio)));

  assert_lpi_group_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !updateReq) |=> ((winId == $past(winId)) || (winGrp == 2'd2)));

  assert_group_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !updateReq && !g1nsEn) |=> $stable(winId));

  assert_addr_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (int'(pendAddr) >= (lpi_sel_pkg::LPI_BASE >> 3)));

  assert_reload_R10: assert property (@(posedge clk) disable iff (!rstN)
    updateReq |=> (winPrio == $past(bestPrioIn)));
endmodule

bind lpi_hppi_sel lpi_hppi_sel_chk #(.MAX_ID_BITS(MAX_ID_BITS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .updateReq  (updateReq),
  .g1nsEn     (g1nsEn),
  .bestPrioIn (bestPrioIn),
  .pendAddr   (pendAddr),
  .busy       (busy),
  .done       (done),
  .winId      (winId),
  .winPrio    (winPrio),
  .winGrp     (winGrp),
  .newWinner  (newWinner)
);

// File: tb/test_lpi_hppi_sel.sv
`timescale 1ns/1ps
module test_lpi_hppi_sel;
  localparam int MAXB = 13;
  localparam int IDW  = MAXB + 1;
  localparam int BASE = 8192;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            updateReq = 1'b0;
  logic [4:0]      idBits = 5'd13;
  logic            g1nsEn = 1'b1;
  logic [IDW-1:0]  bestIdIn = '0;
  logic [7:0]      bestPrioIn = 8'hFF;
  logic [1:0]      bestGrpIn = 2'd0;
  logic [IDW-4:0]  pendAddr;
  logic [7:0]      pendByte;
  logic [IDW-1:0]  cfgIdx;
  logic [7:0]      cfgByte;
  logic            busy, done, newWinner;
  logic [IDW-1:0]  winId;
  logic [7:0]      winPrio;
  logic [1:0]      winGrp;

  logic [7:0] pendMem [0:2047];
  logic [7:0] cfgMem  [0:16383];

  int vectors = 0;
  int errors  = 0;
  int expId, expPrio, expGrp, expNew, expLen;

  always #10 clk = ~clk;

  assign pendByte = pendMem[pendAddr];
  assign cfgByte  = cfgMem[cfgIdx];

  lpi_hppi_sel #(.MAX_ID_BITS(MAXB)) i_lpi_hppi_sel (
    .clk(clk), .rstN(rstN), .updateReq(updateReq), .idBits(idBits),
    .g1nsEn(g1nsEn), .bestIdIn(bestIdIn), .bestPrioIn(bestPrioIn),
    .bestGrpIn(bestGrpIn), .pendAddr(pendAddr), .pendByte(pendByte),
    .cfgIdx(cfgIdx), .cfgByte(cfgByte), .busy(busy), .done(done),
    .winId(winId), .winPrio(winPrio), .winGrp(winGrp), .newWinner(newWinner)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearMems();
    for (int i = 0; i < 2048; i++) pendMem[i] = 8'h00;
    for (int i = 0; i < 16384; i++) cfgMem[i] = 8'h00;
  endtask

  task automatic setPend(input int id);
    pendMem[id >> 3][id & 7] = 1'b1;
  endtask

  // Expected result from the selection rules
  task automatic model();
    int k, last;
    k = (idBits > MAXB) ? MAXB : int'(idBits);
    last = (1 << (k + 1)) - 1;
    expId = int'(bestIdIn); expPrio = int'(bestPrioIn);
    expGrp = int'(bestGrpIn); expNew = 0;
    expLen = (last < BASE) ? 0 : last - BASE + 1;
    for (int id = BASE; id <= last; id++) begin
      logic [7:0] c;
      int p;
      c = cfgMem[id - BASE];
      p = int'({c[7:2], 2'b00});
      if (pendMem[id >> 3][id & 7] && c[0] && g1nsEn) begin
        if (p < expPrio || (p == expPrio && id < expId)) begin
          expId = id; expPrio = p; expGrp = 2; expNew = 1;
        end
      end
    end
  endtask

  task automatic pulseReq();
    @(negedge clk); updateReq = 1'b1;
    @(posedge clk);
    @(negedge clk); updateReq = 1'b0;
  endtask

  // Waits for done; cycle count starts at the sampling edge
  task automatic waitDone(input string tag);
    int cnt = 1;
    if (!done) begin
      while (!done && cnt < 70000) begin
        if (cnt == 3) check({tag, " R2 busy mid-sweep"}, int'(busy), 1);
        @(negedge clk);
        if (!done) cnt++;
      end
    end else cnt = 0;
    check({tag, " R2/R3 sweep length"}, cnt, expLen);
    check({tag, " winId"}, int'(winId), expId);
    check({tag, " winPrio"}, int'(winPrio), expPrio);
    check({tag, " R7 winGrp"}, int'(winGrp), expGrp);
    check({tag, " R9 newWinner"}, int'(newWinner), expNew);
    @(negedge clk);
    check({tag, " R2 done one cycle"}, int'(done), 0);
    check({tag, " R9 newWinner drops"}, int'(newWinner), 0);
  endtask

  task automatic runScan(input string tag);
    model();
    pulseReq();
    waitDone(tag);
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    clearMems();
    #35 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 newWinner", int'(newWinner), 0);

    // R3 empty range: idBits 12 gives upper bound 8191
    for (int i = 1024; i < 2048; i++) pendMem[i] = 8'hFF;
    for (int i = 0; i < 8192; i++) cfgMem[i] = 8'h01;
    idBits = 5'd12; bestIdIn = 14'd40; bestPrioIn = 8'h80; bestGrpIn = 2'd1;
    runScan("R3 empty");

    // R11/R5/R7/R8 single LPI 9000, bit1 set in config (ignored)
    clearMems();
    idBits = 5'd13; bestIdIn = 14'd1023; bestPrioIn = 8'hFF; bestGrpIn = 2'd0;
    setPend(9000); cfgMem[9000 - BASE] = 8'h43;
    runScan("R11 single");
    check("R5 priority masking", int'(winPrio), 8'h40);

    // R4 enable bit cleared
    cfgMem[9000 - BASE] = 8'h42;
    runScan("R4 enable off");

    // R4 group enable cleared
    cfgMem[9000 - BASE] = 8'h41; g1nsEn = 1'b0;
    runScan("R4 group off");
    g1nsEn = 1'b1;

    // R6 tie: incoming lower ID keeps equal priority
    clearMems();
    setPend(8300); cfgMem[8300 - BASE] = 8'h21;
    setPend(8200); cfgMem[8200 - BASE] = 8'h21;
    bestIdIn = 14'd50; bestPrioIn = 8'h20; bestGrpIn = 2'd1;
    runScan("R6 tie incoming");
    bestPrioIn = 8'h24;
    runScan("R6 tie lpi lowest");

    // R5/R6 dense arithmetic pattern
    clearMems();
    for (int id = BASE; id < 16384; id++) begin
      if (id % 3 == 0) setPend(id);
      cfgMem[id - BASE] = {6'((id * 7) % 64), 1'b0, 1'((id % 5) != 0)};
    end
    bestIdIn = 14'd100; bestPrioIn = 8'h10; bestGrpIn = 2'd1;
    runScan("R6 dense");
    bestPrioIn = 8'hFF;
    runScan("R11 dense none");

    // R3 clamp: oversized width code
    idBits = 5'd20; bestPrioIn = 8'h08;
    runScan("R3 clamp");

    // R10 restart mid-sweep with a better incoming candidate
    clearMems();
    idBits = 5'd13; setPend(9000); cfgMem[9000 - BASE] = 8'h41;
    bestIdIn = 14'd70; bestPrioIn = 8'hFF; bestGrpIn = 2'd0;
    pulseReq();
    for (int i = 0; i < 100; i++) @(negedge clk);
    check("R10 busy before restart", int'(busy), 1);
    bestIdIn = 14'd33; bestPrioIn = 8'h10; bestGrpIn = 2'd1;
    runScan("R10 restart");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule